// File: doc/BRIEF.md
# Fill-Order Stack Replacement Selector

This block chooses which way of a single cache set is overwritten when a new block arrives. It does not rank the ways by recency of use. It ranks them by the order in which they were filled. Position 0 holds the newest fill, and the oldest fill sits at position WAYS-1. Each way also carries a flag that records whether the way has produced a hit since it arrived at its present position. A programmable knee splits the stack in two. Above the knee, blocks are still expected to be reused. Below it, they are assumed to be dead.

When a fill request arrives, the block reports a victim one cycle later. In the same clock edge it moves the victim to the top of the stack and pushes the blocks that sat above the victim one step down. The preferred victim is the highest block above the knee that has not hit at its current position. A small pseudo-random generator sometimes skips that candidate. The skipped block then keeps sinking and can stay resident past the knee for reuse far in the future. The surrounding cache logic supplies the hit way and the knee value. Tag matching and data storage are done outside this block.

Top module: `fos_select`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `victim_vld` is 0. After reset every way is invalid, and way w sits at stack position w.
- R2: `victim_vld` is 1 in the cycle after each cycle with `fill_req` high and 0 in every other cycle. `victim_way` is meaningful only while `victim_vld` is 1.
- R3: If any way is invalid, the victim is the lowest-numbered invalid way, whatever the stack positions, flags or knee.
- R4: If all ways are valid, the victim is the way with the smallest position number p such that p < `knee` and its hit flag is clear. Position 0 is the newest fill.
- R5: On a fill, the victim goes to position 0, becomes valid and has its hit flag cleared. Every way whose position is smaller than the victim's old position moves down by one and has its hit flag cleared. All other ways keep their position and flag.
- R6: A hit on a valid way sets that way's hit flag without changing any position. A hit on an invalid way has no effect. A hit on a way that moves in the same cycle's fill leaves its flag clear.
- R7: If all ways are valid and no way qualifies under R4, the victim is the way at position WAYS-1.
- R8: A 16-bit generator, seeded with `LFSR_SEED`, advances once per fill as l = {l[14:0], l[15]^l[13]^l[12]^l[10]}. When its value before the advance has bits [2:0] equal to 000, the first qualifying way is skipped. The second qualifying way (in position order) becomes the victim, or the way at position WAYS-1 if there is no second qualifying way. This requirement applies only when all ways are valid.
- R9: With `knee` = 0 and all ways valid, every victim is the way at position WAYS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_req | input | 1 | Request a victim and push the new block |
| hit_vld | input | 1 | A lookup hit this set |
| hit_way | input | $clog2(WAYS) | Way that hit |
| knee | input | $clog2(WAYS) | Positions strictly below this number are above the knee |
| victim_vld | output | 1 | Victim report valid, one cycle after `fill_req` |
| victim_way | output | $clog2(WAYS) | Chosen victim way |

## Verification
The hardest situation to reach is a skipped candidate. Reaching it needs the generator's low three bits to be zero on a fill cycle while the set is full and at least one way above the knee has a clear flag. The bench keeps a step-by-step model of the generator and of the stack. It issues long runs of random fills mixed with hits, so that the set stays full and skip cycles arrive regularly. It repeats these runs for every knee value of a four-way configuration, which also covers the empty-knee and all-flagged cases that fall through to the bottom of the stack.

// File: rtl/fos_pkg.sv
package fos_pkg;
   function automatic int idx_w(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
   localparam logic [15:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/fos_lfsr.sv
module fos_lfsr #(
   parameter logic [15:0] SEED = 16'hACE1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        adv,
   output logic [15:0] state
);
   logic fb;
   always_comb fb = state[15] ^ state[13] ^ state[12] ^ state[10];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   state <= SEED;
      else if (adv) state <= {state[14:0], fb};
   end
endmodule

// File: rtl/fos_pick.sv
module fos_pick #(
   parameter int WAYS = 8,
   localparam int IW  = fos_pkg::idx_w(WAYS)
) (
   input  logic [WAYS-1:0][IW-1:0] pos,
   input  logic [WAYS-1:0]         valid,
   input  logic [WAYS-1:0]         hflag,
   input  logic [IW-1:0]           knee,
   input  logic                    skip,
   output logic [IW-1:0]           victim
);
   logic [WAYS-1:0][IW-1:0] way_at;
   logic [IW-1:0]           inv_way, first_w, second_w;
   logic                    inv_any;
   int                      nq;

   always_comb begin
      way_at = '0;
      for (int w = 0; w < WAYS; w++) way_at[pos[w]] = IW'(w);
   end

   always_comb begin
      inv_any = 1'b0;
      inv_way = '0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (!valid[w]) begin
            inv_any = 1'b1;
            inv_way = IW'(w);
         end
      end
   end

   always_comb begin
      nq       = 0;
      first_w  = '0;
      second_w = '0;
      for (int p = 0; p < WAYS; p++) begin
         if ((IW'(p) < knee) && valid[way_at[p]] && !hflag[way_at[p]]) begin
            if (nq == 0)      first_w  = way_at[p];
            else if (nq == 1) second_w = way_at[p];
            nq = nq + 1;
         end
      end
   end

   always_comb begin
      if (inv_any)                victim = inv_way;
      else if (nq >= 1 && !skip)  victim = first_w;
      else if (nq >= 2 && skip)   victim = second_w;
      else                        victim = way_at[WAYS-1];
   end
endmodule

// File: rtl/fos_stack.sv
module fos_stack #(
   parameter int WAYS = 8,
   localparam int IW  = fos_pkg::idx_w(WAYS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fill,
   input  logic [IW-1:0]           victim,
   input  logic                    hit_vld,
   input  logic [IW-1:0]           hit_way,
   output logic [WAYS-1:0][IW-1:0] pos,
   output logic [WAYS-1:0]         valid,
   output logic [WAYS-1:0]         hflag
);
   logic [IW-1:0] vpos;
   always_comb vpos = pos[victim];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic is_vic, sinks, hit_me;
      always_comb begin
         is_vic = fill && (victim == IW'(w));
         sinks  = fill && !is_vic && (pos[w] < vpos);
         hit_me = hit_vld && (hit_way == IW'(w)) && valid[w];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pos[w]   <= IW'(w);
            valid[w] <= 1'b0;
            hflag[w] <= 1'b0;
         end else if (is_vic) begin
            pos[w]   <= '0;
            valid[w] <= 1'b1;
            hflag[w] <= 1'b0;
         end else if (sinks) begin
            pos[w]   <= pos[w] + 1'b1;
            hflag[w] <= 1'b0;
         end else if (hit_me) begin
            hflag[w] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/fos_select.sv
module fos_select #(
   parameter int          WAYS      = 8,
   parameter bit          ESCAPE_EN = 1'b1,
   parameter logic [15:0] LFSR_SEED = 16'hACE1,
   localparam int         IW        = fos_pkg::idx_w(WAYS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fill_req,
   input  logic          hit_vld,
   input  logic [IW-1:0] hit_way,
   input  logic [IW-1:0] knee,
   output logic          victim_vld,
   output logic [IW-1:0] victim_way
);
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("fos_select: WAYS must be a power of two, at least 2");
   end
   if (ESCAPE_EN && LFSR_SEED == 16'h0000) begin : g_bad_seed
      $error("fos_select: LFSR_SEED must be nonzero");
   end

   logic [WAYS-1:0][IW-1:0] pos;
   logic [WAYS-1:0]         way_valid, hit_flag;
   logic [IW-1:0]           pick;
   logic                    skip;

   if (ESCAPE_EN) begin : g_escape
      logic [15:0] rnd;
      fos_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
         .clk(clk), .rst_n(rst_n), .adv(fill_req), .state(rnd));
      always_comb skip = (rnd[2:0] == 3'b000);
   end else begin : g_no_escape
      always_comb skip = 1'b0;
   end

   fos_pick #(.WAYS(WAYS)) u_pick (
      .pos(pos), .valid(way_valid), .hflag(hit_flag),
      .knee(knee), .skip(skip), .victim(pick));

   fos_stack #(.WAYS(WAYS)) u_stack (
      .clk(clk), .rst_n(rst_n), .fill(fill_req), .victim(pick),
      .hit_vld(hit_vld), .hit_way(hit_way),
      .pos(pos), .valid(way_valid), .hflag(hit_flag));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         victim_vld <= 1'b0;
         victim_way <= '0;
      end else begin
         victim_vld <= fill_req;
         if (fill_req) victim_way <= pick;
      end
   end
endmodule

// File: rtl/fos_select_chk.sv
module fos_select_chk #(
   parameter int  WAYS = 8,
   localparam int IW   = fos_pkg::idx_w(WAYS)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    fill_req,
   input logic                    hit_vld,
   input logic [IW-1:0]           hit_way,
   input logic [IW-1:0]           knee,
   input logic                    victim_vld,
   input logic [IW-1:0]           victim_way,
   input logic [WAYS-1:0][IW-1:0] pos,
   input logic [WAYS-1:0]         way_valid,
   input logic [WAYS-1:0]         hit_flag
);
   logic [IW-1:0] bottom_way;
   always_comb begin
      bottom_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (pos[w] == IW'(WAYS-1)) bottom_way = IW'(w);
   end

   AST_VLD_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |=> victim_vld); // R2
   AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_req |=> !victim_vld); // R2
   AST_WAY0_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !way_valid[0]) |=> (victim_way == '0)); // R3
   AST_VICTIM_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      victim_vld |-> (pos[victim_way] == '0 && way_valid[victim_way])); // R5
   AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vld && !fill_req && way_valid[hit_way]) |=> hit_flag[$past(hit_way)]); // R6
   AST_EMPTY_KNEE_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && (&way_valid) && knee == '0) |=> (victim_way == $past(bottom_way))); // R9
endmodule

bind fos_select fos_select_chk #(.WAYS(WAYS)) u_chk (
   .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .hit_vld(hit_vld),
   .hit_way(hit_way), .knee(knee), .victim_vld(victim_vld),
   .victim_way(victim_way), .pos(pos), .way_valid(way_valid),
   .hit_flag(hit_flag));

// File: tb/sim_fos_select.sv
`timescale 1ns/1ps
module sim_fos_select;
   localparam int          WAYS = 4;
   localparam int          IW   = 2;
   localparam logic [15:0] SEED = 16'hACE1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fill_req = 1'b0, hit_vld = 1'b0;
   logic [IW-1:0] hit_way = '0, knee = '0;
   logic          victim_vld;
   logic [IW-1:0] victim_way;

   int  n_cmp = 0, n_bad = 0;
   bit  done = 1'b0;

   int          mpos [WAYS];
   bit          mval [WAYS];
   bit          mhf  [WAYS];
   logic [15:0] mlfsr;

   always #10 clk = ~clk;

   fos_select #(.WAYS(WAYS), .ESCAPE_EN(1'b1), .LFSR_SEED(SEED)) u0 (
      .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .hit_vld(hit_vld),
      .hit_way(hit_way), .knee(knee), .victim_vld(victim_vld),
      .victim_way(victim_way));

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   task automatic model_reset();
      for (int w = 0; w < WAYS; w++) begin
         mpos[w] = w; mval[w] = 0; mhf[w] = 0;
      end
      mlfsr = SEED;
   endtask

   // expected victim from the requirements; tag names the rule applied
   task automatic predict(output int v, output string tag);
      int at[WAYS];
      int q1, q2, nq;
      bit sk;
      for (int w = 0; w < WAYS; w++) at[mpos[w]] = w;
      v = -1;
      for (int w = WAYS-1; w >= 0; w--) if (!mval[w]) v = w;
      if (v >= 0) begin tag = "R3"; return; end
      nq = 0; q1 = 0; q2 = 0;
      for (int p = 0; p < WAYS; p++)
         if (p < int'(knee) && !mhf[at[p]]) begin
            if (nq == 0) q1 = at[p]; else if (nq == 1) q2 = at[p];
            nq++;
         end
      sk = (mlfsr[2:0] == 3'b000);
      if (nq >= 1 && !sk)      begin v = q1; tag = "R4 R5 R6"; end
      else if (nq >= 2 && sk)  begin v = q2; tag = "R8"; end
      else begin
         v = at[WAYS-1];
         tag = (knee == 0) ? "R9" : (sk && nq == 1) ? "R8" : "R7";
      end
   endtask

   task automatic model_update(input bit f, input int v, input bit h, input int hw);
      int vp;
      if (f) begin
         vp = mpos[v];
         for (int w = 0; w < WAYS; w++) begin
            if (w == v) begin mpos[w] = 0; mval[w] = 1; mhf[w] = 0; end
            else if (mpos[w] < vp) begin mpos[w]++; mhf[w] = 0; end
            else if (h && hw == w && mval[w]) mhf[w] = 1;
         end
         mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
      end else if (h && mval[hw]) mhf[hw] = 1;
   endtask

   // called at a negedge: drive, clock, check at following negedge
   task automatic step(input bit f, input bit h, input int hw);
      int    v;
      string tag;
      fill_req = f; hit_vld = h; hit_way = IW'(hw);
      predict(v, tag);
      @(posedge clk);
      model_update(f, v, h, hw);
      @(negedge clk);
      check(victim_vld == f, "R2", int'(victim_vld), int'(f));
      if (f) check(victim_way == IW'(v), tag, int'(victim_way), v);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; fill_req = 0; hit_vld = 0;
      repeat (2) @(negedge clk);
      check(victim_vld == 1'b0, "R1", int'(victim_vld), 0);
      rst_n = 1'b1;
      model_reset();
      @(negedge clk);
      check(victim_vld == 1'b0, "R1", int'(victim_vld), 0);
   endtask

   initial begin
      model_reset();
      @(negedge clk);
      for (int k = 0; k < WAYS; k++) begin
         knee = IW'(k);
         do_reset();
         // R3: fresh set fills ways 0..WAYS-1 in order, even with hits to invalid ways
         for (int i = 0; i < WAYS; i++) step(1'b1, 1'b1, WAYS-1);
         for (int i = 0; i < 1500; i++) begin
            bit f, h;
            f = ($urandom_range(0, 99) < 55);
            h = ($urandom_range(0, 99) < 45);
            step(f, h, $urandom_range(0, WAYS-1));
         end
         // R6/R7: flag every way, then fills must come from the bottom
         for (int w = 0; w < WAYS; w++) step(1'b0, 1'b1, w);
         for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0);
      end
      // knee changes on the fly
      for (int i = 0; i < 2000; i++) begin
         knee = IW'($urandom_range(0, WAYS-1));
         step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, WAYS-1));
      end
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule